// File: doc/BRIEF.md
# LPC DMA peripheral cycle engine

This block sits on the peripheral side of a 4-bit multiplexed LPC bus and follows the DMA cycles the host runs there. It watches for a start frame and reads the header nibbles that follow: cycle type and direction, channel with its terminal-count bit, and transfer size. It then steps through the byte phases, the bus turnarounds and its own SYNC replies.

When the host writes to the peripheral, the engine assembles each byte from two nibbles and presents it on a local byte-valid strobe. When the host reads from the peripheral, which includes verify transfers, the engine raises a byte-request strobe, samples the local byte and drives it out one nibble at a time. A terminal-count flag goes with the strobe of the final byte of the coded size.

A grant can still arrive after the peripheral has withdrawn its request. A configuration bit then picks one of two responses. The engine can stay silent so that the host aborts the cycle. It can also run the cycle to the end with filler data and no local strobes.

Top module: `lpcdma_target`

## Requirements
- R1: A cycle starts when `lframe_n` is low while `lad_in` is 0000b. If `lframe_n` is low in any later clock, the current cycle ends. `lad_oe` is then low in the next clock. A low `lframe_n` clock that carries 0000b starts a fresh header.
- R2: The nibble after the start is the cycle type. Bits [3:2] equal to 10b mark a DMA cycle, and bit 1 gives the direction: 0 means host to peripheral, 1 means peripheral to host. `cyc_to_host` shows that bit. Any other type leaves the bus undriven until the next start.
- R3: The nibble after the type is the channel nibble. `cyc_chan` shows bits [2:0] of it, and bit 3 is latched as the terminal-count bit.
- R4: The nibble after the channel is the size nibble. Bits [1:0] equal to 00b give one byte and 01b gives two bytes. Any other value leaves the bus undriven until the next start.
- R5: In a host-to-peripheral cycle, each byte takes four clocks on the bus. The first two are the low nibble and then the high nibble, both driven by the host. The next two are turnaround. In the first turnaround clock `byte_valid` pulses with the byte on `byte_data`. The SYNC sequence follows. After it, the engine drives 1111b for one clock and then releases the bus.
- R6: Every SYNC sequence is `cfg_wait_cnt` wait nibbles followed by one ready nibble 0000b. The wait nibble is 0101b when `cfg_long_wait` is 0 and 0110b when it is 1.
- R7: A peripheral-to-host cycle (DMA write or verify) runs as follows. It begins with two turnaround clocks. Then, for each byte, a SYNC sequence is followed by the low nibble and then the high nibble of the byte. `byte_req` pulses in the clock of the ready nibble, and `byte_in` is sampled in that clock. After the last byte the engine drives 1111b for one clock and then releases the bus.
- R8: `tc_out` pulses together with the strobe of the single byte of a one-byte transfer, or of the second byte of a two-byte transfer, when the latched terminal-count bit is 1. It never pulses at any other time.
- R9: `dreq_active` is sampled in the channel-nibble clock. If it is low there and `cfg_finish_stale` is 0, the engine does not drive the bus for the rest of that cycle.
- R10: If `dreq_active` is low in the channel-nibble clock and `cfg_finish_stale` is 1, the engine runs the full bus sequence anyway. It raises no `byte_valid`, `byte_req` or `tc_out`, and in a peripheral-to-host cycle it drives 00h as data.
- R11: After reset `lad_oe`, `byte_valid`, `byte_req` and `tc_out` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lframe_n | input | 1 | Frame strobe from the host, active low |
| lad_in | input | 4 | Nibble seen on the bus |
| lad_out | output | 4 | Nibble the engine drives |
| lad_oe | output | 1 | Drive enable for `lad_out` |
| dreq_active | input | 1 | Local request still pending |
| cfg_finish_stale | input | 1 | 1: complete cycles granted after withdrawal; 0: ignore them |
| cfg_wait_cnt | input | WAIT_W | Wait nibbles placed before each ready SYNC |
| cfg_long_wait | input | 1 | Use the long-wait code instead of the short-wait code |
| byte_valid | output | 1 | Host-to-peripheral byte ready on `byte_data` |
| byte_data | output | 8 | Assembled byte |
| byte_req | output | 1 | Engine samples `byte_in` in this clock |
| byte_in | input | 8 | Local byte for peripheral-to-host transfers |
| tc_out | output | 1 | Final byte of the terminal-count transfer |
| cyc_chan | output | 3 | Channel of the current or last cycle |
| cyc_to_host | output | 1 | Direction of the current or last cycle |

## Verification
The bench aims at the terminal-count placement in two-byte transfers. An engine that reported the latched bit at once would flag the first byte as well. It also checks the nibble order and the wait count, since an off-by-one wait counter shifts every data nibble by one clock. Withdrawn requests are run in both configurations: a faulty engine would either drive the bus in a cycle it should ignore or pass filler data to the local side. Finally, `lframe_n` is dropped in the middle of a SYNC sequence and in the middle of a header. An engine that misses the abort would keep driving the bus or misread the restarted header.

// File: rtl/lpcdma_pkg.sv
package lpcdma_pkg;

  localparam int NIB_W  = 4;
  localparam int BYTE_W = 2 * NIB_W;
  localparam int CH_W   = 3;

  localparam logic [NIB_W-1:0] NIB_START  = 4'b0000;
  localparam logic [NIB_W-1:0] SYNC_READY = 4'b0000;
  localparam logic [NIB_W-1:0] SYNC_SHORT = 4'b0101;
  localparam logic [NIB_W-1:0] SYNC_LONG  = 4'b0110;
  localparam logic [NIB_W-1:0] NIB_IDLE   = 4'b1111;

  typedef enum logic [3:0] {
    S_IDLE, S_TYPE, S_CHAN, S_SIZE,
    S_HTAR1, S_HTAR2, S_HLO, S_HHI,
    S_SYNC, S_PLO, S_PHI, S_PTAR1, S_PTAR2
  } dstate_e;

  function automatic logic nib_is_dma(input logic [NIB_W-1:0] n);
    return n[3:2] == 2'b10;
  endfunction

  function automatic logic nib_to_host(input logic [NIB_W-1:0] n);
    return n[1];
  endfunction

  function automatic logic nib_size_ok(input logic [NIB_W-1:0] n);
    return n[1] == 1'b0;
  endfunction

  function automatic logic nib_size_wide(input logic [NIB_W-1:0] n);
    return n[0];
  endfunction

  function automatic logic is_last_byte(input logic wide, input logic idx);
    return !wide || idx;
  endfunction

  function automatic logic [NIB_W-1:0] sync_wait_code(input logic long_w);
    return long_w ? SYNC_LONG : SYNC_SHORT;
  endfunction

endpackage

// File: rtl/lpcdma_wait_ctr.sv
module lpcdma_wait_ctr #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] init,
  input  logic         run,
  output logic         done
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (load)
      cnt_q <= init;
    else if (run && cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/lpcdma_byte_reg.sv
module lpcdma_byte_reg
  import lpcdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_lo,
  input  logic              cap_hi,
  input  logic [NIB_W-1:0]  nib_in,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_val,
  output logic [BYTE_W-1:0] byte_q,
  output logic [NIB_W-1:0]  nib_lo,
  output logic [NIB_W-1:0]  nib_hi
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      byte_q <= '0;
    else if (load)
      byte_q <= load_val;
    else if (cap_lo)
      byte_q[NIB_W-1:0] <= nib_in;
    else if (cap_hi)
      byte_q[BYTE_W-1:NIB_W] <= nib_in;
  end

  assign nib_lo = byte_q[NIB_W-1:0];
  assign nib_hi = byte_q[BYTE_W-1:NIB_W];
endmodule

// File: rtl/lpcdma_bus_drv.sv
module lpcdma_bus_drv
  import lpcdma_pkg::*;
(
  input  dstate_e          state,
  input  logic             wait_done,
  input  logic             long_wait,
  input  logic [NIB_W-1:0] nib_lo,
  input  logic [NIB_W-1:0] nib_hi,
  output logic             oe,
  output logic [NIB_W-1:0] nib_out
);
  always_comb begin
    oe      = 1'b0;
    nib_out = NIB_IDLE;
    case (state)
      S_SYNC: begin
        oe      = 1'b1;
        nib_out = wait_done ? SYNC_READY : sync_wait_code(long_wait);
      end
      S_PLO: begin
        oe      = 1'b1;
        nib_out = nib_lo;
      end
      S_PHI: begin
        oe      = 1'b1;
        nib_out = nib_hi;
      end
      S_PTAR1: begin
        oe      = 1'b1;
        nib_out = NIB_IDLE;
      end
      default: begin
        oe      = 1'b0;
        nib_out = NIB_IDLE;
      end
    endcase
  end
endmodule

// File: rtl/lpcdma_target.sv
module lpcdma_target
  import lpcdma_pkg::*;
#(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lframe_n,
  input  logic [NIB_W-1:0]  lad_in,
  output logic [NIB_W-1:0]  lad_out,
  output logic              lad_oe,
  input  logic              dreq_active,
  input  logic              cfg_finish_stale,
  input  logic [WAIT_W-1:0] cfg_wait_cnt,
  input  logic              cfg_long_wait,
  output logic              byte_valid,
  output logic [BYTE_W-1:0] byte_data,
  output logic              byte_req,
  input  logic [BYTE_W-1:0] byte_in,
  output logic              tc_out,
  output logic [CH_W-1:0]   cyc_chan,
  output logic              cyc_to_host
);

  dstate_e         state_q, state_d;
  logic            to_host_q;
  logic [CH_W-1:0] chan_q;
  logic            tc_q;
  logic            wide_q;
  logic            stale_q;
  logic            idx_q;

  // named internal events, also watched by the checker
  logic            last_byte;
  logic            in_sync;
  logic            in_idle;
  logic            cap_lo;
  logic            cap_hi;
  logic            wait_done;
  logic            wait_load;
  logic            load_byte;
  logic [BYTE_W-1:0] load_val;
  logic [NIB_W-1:0]  nib_lo;
  logic [NIB_W-1:0]  nib_hi;

  assign last_byte = is_last_byte(wide_q, idx_q);
  assign in_sync   = (state_q == S_SYNC);
  assign in_idle   = (state_q == S_IDLE);
  assign cap_lo    = (state_q == S_HLO) && lframe_n;
  assign cap_hi    = (state_q == S_HHI) && lframe_n;

  // next-state logic
  always_comb begin
    state_d = state_q;
    if (!lframe_n) begin
      state_d = (lad_in == NIB_START) ? S_TYPE : S_IDLE;
    end else begin
      case (state_q)
        S_IDLE:  state_d = S_IDLE;
        S_TYPE:  state_d = nib_is_dma(lad_in) ? S_CHAN : S_IDLE;
        S_CHAN:  state_d = (!dreq_active && !cfg_finish_stale) ? S_IDLE : S_SIZE;
        S_SIZE: begin
          if (!nib_size_ok(lad_in))
            state_d = S_IDLE;
          else
            state_d = to_host_q ? S_HTAR1 : S_HLO;
        end
        S_HLO:   state_d = S_HHI;
        S_HHI:   state_d = S_HTAR1;
        S_HTAR1: state_d = S_HTAR2;
        S_HTAR2: state_d = S_SYNC;
        S_SYNC: begin
          if (wait_done)
            state_d = to_host_q ? S_PLO : S_PTAR1;
        end
        S_PLO:   state_d = S_PHI;
        S_PHI:   state_d = last_byte ? S_PTAR1 : S_SYNC;
        S_PTAR1: state_d = S_PTAR2;
        S_PTAR2: state_d = (!to_host_q && !last_byte) ? S_HLO : S_IDLE;
        default: state_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      state_q <= S_IDLE;
    else
      state_q <= state_d;
  end

  // header fields and byte index
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      to_host_q <= 1'b0;
      chan_q    <= '0;
      tc_q      <= 1'b0;
      wide_q    <= 1'b0;
      stale_q   <= 1'b0;
      idx_q     <= 1'b0;
    end else if (lframe_n) begin
      case (state_q)
        S_TYPE: to_host_q <= nib_to_host(lad_in);
        S_CHAN: begin
          chan_q  <= lad_in[CH_W-1:0];
          tc_q    <= lad_in[NIB_W-1];
          stale_q <= !dreq_active;
        end
        S_SIZE: begin
          wide_q <= nib_size_wide(lad_in);
          idx_q  <= 1'b0;
        end
        S_PHI:   if (!last_byte) idx_q <= 1'b1;
        S_PTAR2: if (!to_host_q && !last_byte) idx_q <= 1'b1;
        default: ;
      endcase
    end
  end

  // SYNC wait counter
  assign wait_load = (state_d == S_SYNC) && (state_q != S_SYNC);

  lpcdma_wait_ctr #(.W(WAIT_W)) u_wait (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (wait_load),
    .init  (cfg_wait_cnt),
    .run   (in_sync),
    .done  (wait_done)
  );

  // byte assembly and supply
  assign load_byte = in_sync && wait_done && to_host_q;
  assign load_val  = stale_q ? '0 : byte_in;

  lpcdma_byte_reg u_byte (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_lo   (cap_lo),
    .cap_hi   (cap_hi),
    .nib_in   (lad_in),
    .load     (load_byte),
    .load_val (load_val),
    .byte_q   (byte_data),
    .nib_lo   (nib_lo),
    .nib_hi   (nib_hi)
  );

  lpcdma_bus_drv u_drv (
    .state     (state_q),
    .wait_done (wait_done),
    .long_wait (cfg_long_wait),
    .nib_lo    (nib_lo),
    .nib_hi    (nib_hi),
    .oe        (lad_oe),
    .nib_out   (lad_out)
  );

  // local strobes
  assign byte_valid  = (state_q == S_HTAR1) && !to_host_q && !stale_q;
  assign byte_req    = load_byte && !stale_q;
  assign tc_out      = (byte_valid || byte_req) && tc_q && last_byte;
  assign cyc_chan    = chan_q;
  assign cyc_to_host = to_host_q;

endmodule

// File: rtl/lpcdma_target_chk.sv
module lpcdma_target_chk
  import lpcdma_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             lframe_n,
  input logic             lad_oe,
  input logic [NIB_W-1:0] lad_out,
  input logic             byte_valid,
  input logic             byte_req,
  input logic             tc_out,
  input logic             in_sync,
  input logic             in_idle,
  input logic             cap_hi,
  input logic             stale_q,
  input logic             last_byte
);
  // R1
  abort_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lframe_n |=> !lad_oe);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle |-> !lad_oe && !byte_valid && !byte_req);

  // R6
  sync_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_sync |-> lad_oe && (lad_out == SYNC_READY || lad_out == SYNC_SHORT ||
                           lad_out == SYNC_LONG));

  // R5
  valid_after_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> $past(cap_hi));

  // R8
  tc_on_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tc_out |-> (byte_valid || byte_req) && last_byte);

  // R10
  stale_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid || byte_req) |-> !stale_q);

  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({byte_valid, byte_req}));
endmodule

bind lpcdma_target lpcdma_target_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lframe_n   (lframe_n),
  .lad_oe     (lad_oe),
  .lad_out    (lad_out),
  .byte_valid (byte_valid),
  .byte_req   (byte_req),
  .tc_out     (tc_out),
  .in_sync    (in_sync),
  .in_idle    (in_idle),
  .cap_hi     (cap_hi),
  .stale_q    (stale_q),
  .last_byte  (last_byte)
);

// File: tb/lpcdma_target_test.sv
`timescale 1ns/1ps
module lpcdma_target_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lframe_n = 1'b1;
  logic [3:0] lad_in = 4'hF;
  logic [3:0] lad_out;
  logic       lad_oe;
  logic       dreq_active = 1'b1;
  logic       cfg_finish_stale = 1'b0;
  logic [3:0] cfg_wait_cnt = 4'd0;
  logic       cfg_long_wait = 1'b0;
  logic       byte_valid;
  logic [7:0] byte_data;
  logic       byte_req;
  logic [7:0] byte_in = 8'h00;
  logic       tc_out;
  logic [2:0] cyc_chan;
  logic       cyc_to_host;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 0;

  // expected strobe: {kind(1=req), tc, data}
  logic [9:0] exp_q[$];

  always #2 clk = ~clk;

  lpcdma_target uut (
    .clk(clk), .rst_n(rst_n), .lframe_n(lframe_n), .lad_in(lad_in),
    .lad_out(lad_out), .lad_oe(lad_oe), .dreq_active(dreq_active),
    .cfg_finish_stale(cfg_finish_stale), .cfg_wait_cnt(cfg_wait_cnt),
    .cfg_long_wait(cfg_long_wait), .byte_valid(byte_valid),
    .byte_data(byte_data), .byte_req(byte_req), .byte_in(byte_in),
    .tc_out(tc_out), .cyc_chan(cyc_chan), .cyc_to_host(cyc_to_host)
  );

  // monitor: pops expected strobes as they appear
  always @(negedge clk) begin
    if (rst_n && (byte_valid || byte_req || tc_out)) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R8/R10 unexpected strobe: valid=%b req=%b tc=%b expected none",
                 byte_valid, byte_req, tc_out);
      end else begin
        logic [9:0] e;
        e = exp_q.pop_front();
        if (byte_req !== e[9] || byte_valid !== !e[9] || tc_out !== e[8] ||
            (!e[9] && byte_data !== e[7:0])) begin
          n_fail++;
          $display("FAIL R5/R7/R8 strobe: req=%b valid=%b tc=%b data=%h expected req=%b tc=%b data=%h",
                   byte_req, byte_valid, tc_out, byte_data, e[9], e[8], e[7:0]);
        end
      end
    end
  end

  task automatic step(input logic fr, input logic [3:0] nib, input logic eoe,
                      input logic [3:0] ev, input string tag);
    @(negedge clk);
    n_chk++;
    if (lad_oe !== eoe || (eoe && lad_out !== ev)) begin
      n_fail++;
      $display("FAIL %s: oe=%b out=%h expected oe=%b out=%h", tag, lad_oe, lad_out, eoe, ev);
    end
    lframe_n = fr;
    lad_in   = nib;
  endtask

  task automatic hdr(input logic to_host, input logic [2:0] ch, input logic tc,
                     input logic [3:0] sz);
    step(1'b0, 4'h0, 1'b0, 4'h0, "R1 start");
    step(1'b1, {2'b10, to_host, 1'b0}, 1'b0, 4'h0, "R2 type");
    step(1'b1, {tc, ch}, 1'b0, 4'h0, "R3 chan");
    step(1'b1, sz, 1'b0, 4'h0, "R4 size");
  endtask

  task automatic sync_seq(input string tag);
    for (int i = 0; i < int'(cfg_wait_cnt); i++)
      step(1'b1, 4'hF, 1'b1, cfg_long_wait ? 4'h6 : 4'h5, tag);
    step(1'b1, 4'hF, 1'b1, 4'h0, tag);
  endtask

  task automatic chk_hdr(input logic to_host, input logic [2:0] ch);
    n_chk++;
    if (cyc_chan !== ch || cyc_to_host !== to_host) begin
      n_fail++;
      $display("FAIL R2/R3 header: chan=%0d dir=%b expected chan=%0d dir=%b",
               cyc_chan, cyc_to_host, ch, to_host);
    end
  endtask

  task automatic dma_read(input logic [2:0] ch, input logic tc, input logic wide,
                          input logic [7:0] d0, input logic [7:0] d1);
    logic stale;
    stale = !dreq_active;
    for (int b = 0; b <= int'(wide); b++) begin
      logic [7:0] d;
      d = (b == 0) ? d0 : d1;
      if (!stale) exp_q.push_back({1'b0, tc && (b == int'(wide)), d});
    end
    hdr(1'b0, ch, tc, {3'b000, wide});
    for (int b = 0; b <= int'(wide); b++) begin
      logic [7:0] d;
      d = (b == 0) ? d0 : d1;
      step(1'b1, d[3:0], 1'b0, 4'h0, "R5 lo");
      step(1'b1, d[7:4], 1'b0, 4'h0, "R5 hi");
      step(1'b1, 4'hF, 1'b0, 4'h0, "R5 tar1");
      step(1'b1, 4'hF, 1'b0, 4'h0, "R5 tar2");
      sync_seq("R6 read sync");
      step(1'b1, 4'hF, 1'b1, 4'hF, "R5 ptar1");
      step(1'b1, 4'hF, 1'b0, 4'h0, "R5 ptar2");
    end
    chk_hdr(1'b0, ch);
  endtask

  task automatic dma_write(input logic [2:0] ch, input logic tc, input logic wide,
                           input logic [7:0] d0, input logic [7:0] d1);
    logic stale;
    stale = !dreq_active;
    for (int b = 0; b <= int'(wide); b++)
      if (!stale) exp_q.push_back({1'b1, tc && (b == int'(wide)), 8'h00});
    hdr(1'b1, ch, tc, {3'b000, wide});
    step(1'b1, 4'hF, 1'b0, 4'h0, "R7 tar1");
    step(1'b1, 4'hF, 1'b0, 4'h0, "R7 tar2");
    for (int b = 0; b <= int'(wide); b++) begin
      logic [7:0] d;
      d = stale ? 8'h00 : ((b == 0) ? d0 : d1);
      byte_in = (b == 0) ? d0 : d1;
      sync_seq("R6 write sync");
      step(1'b1, 4'hF, 1'b1, d[3:0], stale ? "R10 lo" : "R7 lo");
      step(1'b1, 4'hF, 1'b1, d[7:4], stale ? "R10 hi" : "R7 hi");
    end
    step(1'b1, 4'hF, 1'b1, 4'hF, "R7 ptar1");
    step(1'b1, 4'hF, 1'b0, 4'h0, "R7 ptar2");
    chk_hdr(1'b1, ch);
  endtask

  task automatic quiet(input int n, input string tag);
    for (int i = 0; i < n; i++)
      step(1'b1, 4'hF, 1'b0, 4'h0, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    @(negedge clk);
    n_chk++;
    if (lad_oe !== 1'b0 || byte_valid !== 1'b0 || byte_req !== 1'b0 || tc_out !== 1'b0) begin
      n_fail++;
      $display("FAIL R11 reset: oe=%b valid=%b req=%b tc=%b expected all 0",
               lad_oe, byte_valid, byte_req, tc_out);
    end

    cfg_wait_cnt = 4'd0; dma_read(3'd1, 1'b0, 1'b0, 8'hA5, 8'h00);
    cfg_wait_cnt = 4'd2; dma_read(3'd5, 1'b1, 1'b1, 8'h3C, 8'hC7);   // R8 second byte only
    cfg_wait_cnt = 4'd1; cfg_long_wait = 1'b1;
    dma_write(3'd2, 1'b1, 1'b0, 8'h96, 8'h00);                         // R8 single byte
    cfg_wait_cnt = 4'd0; cfg_long_wait = 1'b0;
    dma_write(3'd6, 1'b1, 1'b1, 8'h1E, 8'hB4);
    cfg_wait_cnt = 4'd3; dma_write(3'd7, 1'b0, 1'b1, 8'h5A, 8'h69);
    cfg_wait_cnt = 4'd1; dma_read(3'd0, 1'b0, 1'b1, 8'hF0, 8'h0F);

    // R2 non-DMA cycle type ignored
    step(1'b0, 4'h0, 1'b0, 4'h0, "R1 start");
    step(1'b1, 4'h0, 1'b0, 4'h0, "R2 type");
    quiet(10, "R2 non-dma ignored");
    // R4 unsupported size ignored
    hdr(1'b1, 3'd3, 1'b0, 4'h2);
    quiet(10, "R4 bad size ignored");

    // R9 withdrawn request, ignore
    dreq_active = 1'b0; cfg_finish_stale = 1'b0;
    hdr(1'b1, 3'd4, 1'b1, 4'h0);
    quiet(10, "R9 stale ignored");
    // R10 withdrawn request, complete with filler
    cfg_finish_stale = 1'b1;
    dma_write(3'd4, 1'b1, 1'b0, 8'hDE, 8'h00);
    dma_read(3'd4, 1'b1, 1'b1, 8'h12, 8'h34);
    dreq_active = 1'b1; cfg_finish_stale = 1'b0;

    // R1 abort during SYNC waits
    cfg_wait_cnt = 4'd3;
    hdr(1'b1, 3'd2, 1'b0, 4'h0);
    step(1'b1, 4'hF, 1'b0, 4'h0, "R7 tar1");
    step(1'b1, 4'hF, 1'b0, 4'h0, "R7 tar2");
    step(1'b0, 4'hF, 1'b1, 4'h5, "R6 wait before abort");
    quiet(4, "R1 abort released");
    // R1 restart in the middle of a header
    step(1'b0, 4'h0, 1'b0, 4'h0, "R1 start");
    step(1'b1, 4'h8, 1'b0, 4'h0, "R2 type");
    cfg_wait_cnt = 4'd0;
    dma_read(3'd6, 1'b1, 1'b0, 8'h7B, 8'h00);

    n_chk++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R5/R7 strobes missing: %0d left expected 0", exp_q.size());
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R1 watchdog: run still active expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule